// File: doc/BRIEF.md
# Microprogrammed Bit-Slice ALU Datapath

This block is a wide arithmetic and logic datapath made of identical 4-bit slices. Each slice holds its share of a two-port register file, its share of an auxiliary Q register, an operand selector, an ALU and an output selector. The carry ripples from the lowest slice to the highest. With the default of ten slices the datapath is 40 bits wide.

A microinstruction is supplied on the `u*` inputs and is captured into an internal word register on the rising clock edge. The captured word then holds the addresses, operand source, function, destination and carry-in steady for one whole cycle. The register file is written from the ALU result only at the clock edge. Its two read outputs pass through level-sensitive holding stages. These stages follow the array while the clock is low and freeze while it is high, so a write at the edge never disturbs the operands being consumed. The external data input reaches the result bus through logic alone. The block contains no path from its result bus back to its own inputs, so an outside bus that routes `yOut` back to `dIn` forms no loop inside it.

Top module: `sliceAluTop`

## Requirements
- R1: A synchronous reset clears every register file entry, the Q register and the captured word. The reset word selects source 0/Q, function add, carry-in 0 and destination 1. While it is active, `yOut` is 0, `zeroFlag` is 1, and the other flags are 0.
- R2: The source code selects the operand pair (R,S): 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0). A is the read at the A address, B is the read at the B address and D is `dIn`.
- R3: The function code selects the operation. 0 is R+S+cin. 1 is S+~R+cin. 2 is R+~S+cin. 3 is R OR S. 4 is R AND S. 5 is (NOT R) AND S. 6 is R XOR S. 7 is R XNOR S.
- R4: For codes 0 to 2, `carryOut` is the carry out of the top bit after chaining through all slices, and `overflowFlag` is the signed two's-complement overflow of the sum. For codes 3 to 7, both flags are 0.
- R5: `zeroFlag` is 1 exactly when the full-width ALU result F is all zeros. `signFlag` equals the top bit of F.
- R6: The destination code sets the writes and the output. 0 loads Q from F and outputs F. 1 writes nothing and outputs F. 2 writes F into entry B and outputs A. 3 writes F into entry B and outputs F. 4 writes F into both entry B and Q and outputs F. Codes 5 to 7 act as 1. A code that does not write an entry or Q leaves it unchanged.
- R7: A register file or Q write takes effect at the clock edge that ends the word's cycle. The word captured at that same edge reads the new value.
- R8: Within the cycle of a word that writes entry B, the A and B operands keep their values from before the write. With destination 2 and equal A and B addresses, `yOut` shows the old contents.
- R9: `dIn` reaches `yOut` through logic alone. A change on `dIn` in mid-cycle shows on `yOut` in the same cycle.
- R10: The `u*` inputs affect nothing until the next rising edge. Changing them in mid-cycle leaves `yOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register file reads are held while it is high |
| rst | input | 1 | Synchronous active-high reset |
| uAAddr | input | ADDR_W | Microword A read address |
| uBAddr | input | ADDR_W | Microword B read and write address |
| uSrc | input | 3 | Microword operand source code |
| uFunc | input | 3 | Microword ALU function code |
| uDest | input | 3 | Microword destination code |
| uCarryIn | input | 1 | Microword carry-in to the lowest slice |
| dIn | input | DATA_W | External data input |
| yOut | output | DATA_W | Result bus, either F or the A operand |
| carryOut | output | 1 | Carry out of the top slice |
| zeroFlag | output | 1 | F is all zeros |
| signFlag | output | 1 | Top bit of F |
| overflowFlag | output | 1 | Signed overflow of an arithmetic function |

## Verification
A word presented before rising edge k executes between edges k and k+1. Its `yOut` and flags become valid in the low half of that cycle, once the read stages are open, and its writes are visible to the word captured at edge k+1. The bench presents each word in the low half of the cycle, waits for the capturing edge, changes `dIn` 1 ns later, and samples all outputs 1 ns after the next falling edge. It keeps its own model of the register file and Q, and updates that model only after comparing the outputs. The combinational `dIn` path and the ignored mid-cycle `u*` changes are checked by sampling again within the same low half, before the next edge.

// File: rtl/sliceAluPkg.sv
`timescale 1ns/1ps
package sliceAluPkg;

  typedef enum logic [2:0] {
    SRC_AQ = 3'd0,
    SRC_AB = 3'd1,
    SRC_ZQ = 3'd2,
    SRC_ZB = 3'd3,
    SRC_ZA = 3'd4,
    SRC_DA = 3'd5,
    SRC_DQ = 3'd6,
    SRC_DZ = 3'd7
  } srcSel_e;

  typedef enum logic [2:0] {
    FN_ADD   = 3'd0,
    FN_SUBR  = 3'd1,
    FN_SUBS  = 3'd2,
    FN_OR    = 3'd3,
    FN_AND   = 3'd4,
    FN_NOTRS = 3'd5,
    FN_XOR   = 3'd6,
    FN_XNOR  = 3'd7
  } aluFn_e;

  typedef enum logic [2:0] {
    DST_QREG  = 3'd0,
    DST_NOP   = 3'd1,
    DST_RAMA  = 3'd2,
    DST_RAMF  = 3'd3,
    DST_RAMQF = 3'd4
  } dest_e;

  typedef struct packed {
    logic qLoad;
    logic rfWrite;
    logic yFromA;
  } ctrlStrobes_t;

endpackage

// File: rtl/sliceAluCtrl.sv
`timescale 1ns/1ps
module sliceAluCtrl
  import sliceAluPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] uAAddr,
  input  logic [ADDR_W-1:0] uBAddr,
  input  logic [2:0]        uSrc,
  input  logic [2:0]        uFunc,
  input  logic [2:0]        uDest,
  input  logic              uCarryIn,
  output ctrlStrobes_t      strobes,
  output logic [ADDR_W-1:0] aAddr,
  output logic [ADDR_W-1:0] bAddr,
  output srcSel_e           src,
  output aluFn_e            fn,
  output logic              cin
);

  logic [2:0] destReg;

  // captured microword: stable for the whole cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      aAddr   <= '0;
      bAddr   <= '0;
      src     <= SRC_ZQ;
      fn      <= FN_ADD;
      destReg <= DST_NOP;
      cin     <= 1'b0;
    end else begin
      aAddr   <= uAAddr;
      bAddr   <= uBAddr;
      src     <= srcSel_e'(uSrc);
      fn      <= aluFn_e'(uFunc);
      destReg <= uDest;
      cin     <= uCarryIn;
    end
  end

  always_comb begin
    strobes = '0;
    case (destReg)
      DST_QREG:  strobes.qLoad = 1'b1;
      DST_RAMA:  begin
        strobes.rfWrite = 1'b1;
        strobes.yFromA  = 1'b1;
      end
      DST_RAMF:  strobes.rfWrite = 1'b1;
      DST_RAMQF: begin
        strobes.rfWrite = 1'b1;
        strobes.qLoad   = 1'b1;
      end
      default:   strobes = '0;
    endcase
  end

endmodule

// File: rtl/sliceRegFile.sv
`timescale 1ns/1ps
module sliceRegFile #(
  parameter int WIDTH    = 4,
  parameter int RF_DEPTH = 16,
  localparam int ADDR_W  = $clog2(RF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wEn,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [WIDTH-1:0]  wData,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [ADDR_W-1:0] bAddr,
  output logic [WIDTH-1:0]  aHold,
  output logic [WIDTH-1:0]  bHold
);

  logic [WIDTH-1:0] mem [RF_DEPTH];

  // edge-clocked write port
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RF_DEPTH; i++) mem[i] <= '0;
    end else if (wEn) begin
      mem[wAddr] <= wData;
    end
  end

  // read holding stages: follow while clk low, freeze while clk high
  always_latch begin
    if (!clk) begin
      aHold <= mem[aAddr];
      bHold <= mem[bAddr];
    end
  end

  // R7
  rf_write_chk: assert property (@(posedge clk) disable iff (rst)
    wEn |=> mem[$past(wAddr)] == $past(wData));

endmodule

// File: rtl/aluSlice.sv
`timescale 1ns/1ps
module aluSlice
  import sliceAluPkg::*;
#(
  parameter int SLICE_W  = 4,
  parameter int RF_DEPTH = 16,
  localparam int ADDR_W  = $clog2(RF_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  input  logic [ADDR_W-1:0]  aAddr,
  input  logic [ADDR_W-1:0]  bAddr,
  input  srcSel_e            src,
  input  aluFn_e             fn,
  input  logic               carryIn,
  input  logic [SLICE_W-1:0] dSlice,
  output logic [SLICE_W-1:0] fSlice,
  output logic [SLICE_W-1:0] ySlice,
  output logic               carryOut,
  output logic               ovfSlice
);

  logic [SLICE_W-1:0] aVal, bVal, qReg;
  logic [SLICE_W-1:0] rOp, sOp, opX, opY, sumBits;
  logic [SLICE_W:0]   ripple;
  logic               isArith;

  sliceRegFile #(
    .WIDTH(SLICE_W),
    .RF_DEPTH(RF_DEPTH)
  ) i_rf (
    .clk(clk),
    .rst(rst),
    .wEn(strobes.rfWrite),
    .wAddr(bAddr),
    .wData(fSlice),
    .aAddr(aAddr),
    .bAddr(bAddr),
    .aHold(aVal),
    .bHold(bVal)
  );

  // operand pairing
  always_comb begin
    case (src)
      SRC_AQ:  begin rOp = aVal;   sOp = qReg; end
      SRC_AB:  begin rOp = aVal;   sOp = bVal; end
      SRC_ZQ:  begin rOp = '0;     sOp = qReg; end
      SRC_ZB:  begin rOp = '0;     sOp = bVal; end
      SRC_ZA:  begin rOp = '0;     sOp = aVal; end
      SRC_DA:  begin rOp = dSlice; sOp = aVal; end
      SRC_DQ:  begin rOp = dSlice; sOp = qReg; end
      default: begin rOp = dSlice; sOp = '0;   end
    endcase
  end

  // function unit with ripple carry
  always_comb begin
    isArith = (fn == FN_ADD) || (fn == FN_SUBR) || (fn == FN_SUBS);
    opX = (fn == FN_SUBR) ? ~rOp : rOp;
    opY = (fn == FN_SUBS) ? ~sOp : sOp;
    ripple[0] = carryIn;
    for (int k = 0; k < SLICE_W; k++) begin
      sumBits[k]  = opX[k] ^ opY[k] ^ ripple[k];
      ripple[k+1] = (opX[k] & opY[k]) | ((opX[k] ^ opY[k]) & ripple[k]);
    end
    case (fn)
      FN_OR:    fSlice = rOp | sOp;
      FN_AND:   fSlice = rOp & sOp;
      FN_NOTRS: fSlice = ~rOp & sOp;
      FN_XOR:   fSlice = rOp ^ sOp;
      FN_XNOR:  fSlice = ~(rOp ^ sOp);
      default:  fSlice = sumBits;
    endcase
    carryOut = isArith & ripple[SLICE_W];
    ovfSlice = isArith & (ripple[SLICE_W] ^ ripple[SLICE_W-1]);
  end

  assign ySlice = strobes.yFromA ? aVal : fSlice;

  always_ff @(posedge clk) begin
    if (rst)                qReg <= '0;
    else if (strobes.qLoad) qReg <= fSlice;
  end

  // R6
  q_load_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.qLoad |=> qReg == $past(fSlice));

endmodule

// File: rtl/sliceAluDatapath.sv
`timescale 1ns/1ps
module sliceAluDatapath
  import sliceAluPkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 10,
  parameter int RF_DEPTH   = 16,
  localparam int DATA_W    = SLICE_W * NUM_SLICES,
  localparam int ADDR_W    = $clog2(RF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [ADDR_W-1:0] bAddr,
  input  srcSel_e           src,
  input  aluFn_e            fn,
  input  logic              cin,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] yOut,
  output logic              carryOut,
  output logic              zeroFlag,
  output logic              signFlag,
  output logic              overflowFlag
);

  logic [DATA_W-1:0]     fBus;
  logic [NUM_SLICES:0]   carryChain;
  logic [NUM_SLICES-1:0] sliceOvf;
  logic [NUM_SLICES-1:0] sliceZero;

  assign carryChain[0] = cin;

  for (genvar g = 0; g < NUM_SLICES; g++) begin : gSlice
    aluSlice #(
      .SLICE_W(SLICE_W),
      .RF_DEPTH(RF_DEPTH)
    ) i_slice (
      .clk(clk),
      .rst(rst),
      .strobes(strobes),
      .aAddr(aAddr),
      .bAddr(bAddr),
      .src(src),
      .fn(fn),
      .carryIn(carryChain[g]),
      .dSlice(dIn[g*SLICE_W +: SLICE_W]),
      .fSlice(fBus[g*SLICE_W +: SLICE_W]),
      .ySlice(yOut[g*SLICE_W +: SLICE_W]),
      .carryOut(carryChain[g+1]),
      .ovfSlice(sliceOvf[g])
    );
    assign sliceZero[g] = ~|fBus[g*SLICE_W +: SLICE_W];
  end

  assign carryOut     = carryChain[NUM_SLICES];
  assign overflowFlag = sliceOvf[NUM_SLICES-1];
  assign zeroFlag     = &sliceZero;
  assign signFlag     = fBus[DATA_W-1];

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    zeroFlag == (fBus == '0));

  // R4
  logic_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (fn inside {FN_OR, FN_AND, FN_NOTRS, FN_XOR, FN_XNOR}) |->
      (sliceOvf == '0 && !carryOut));

  // R9
  pass_d_chk: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_DZ && fn == FN_OR) |-> fBus == dIn);

endmodule

// File: rtl/sliceAluTop.sv
`timescale 1ns/1ps
module sliceAluTop
  import sliceAluPkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 10,
  parameter int RF_DEPTH   = 16,
  localparam int DATA_W    = SLICE_W * NUM_SLICES,
  localparam int ADDR_W    = $clog2(RF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] uAAddr,
  input  logic [ADDR_W-1:0] uBAddr,
  input  logic [2:0]        uSrc,
  input  logic [2:0]        uFunc,
  input  logic [2:0]        uDest,
  input  logic              uCarryIn,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] yOut,
  output logic              carryOut,
  output logic              zeroFlag,
  output logic              signFlag,
  output logic              overflowFlag
);

  ctrlStrobes_t      strobes;
  logic [ADDR_W-1:0] aAddr, bAddr;
  srcSel_e           src;
  aluFn_e            fn;
  logic              cin;

  sliceAluCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk),
    .rst(rst),
    .uAAddr(uAAddr),
    .uBAddr(uBAddr),
    .uSrc(uSrc),
    .uFunc(uFunc),
    .uDest(uDest),
    .uCarryIn(uCarryIn),
    .strobes(strobes),
    .aAddr(aAddr),
    .bAddr(bAddr),
    .src(src),
    .fn(fn),
    .cin(cin)
  );

  sliceAluDatapath #(
    .SLICE_W(SLICE_W),
    .NUM_SLICES(NUM_SLICES),
    .RF_DEPTH(RF_DEPTH)
  ) i_dp (
    .clk(clk),
    .rst(rst),
    .strobes(strobes),
    .aAddr(aAddr),
    .bAddr(bAddr),
    .src(src),
    .fn(fn),
    .cin(cin),
    .dIn(dIn),
    .yOut(yOut),
    .carryOut(carryOut),
    .zeroFlag(zeroFlag),
    .signFlag(signFlag),
    .overflowFlag(overflowFlag)
  );

endmodule

// File: tb/test_sliceAluTop.sv
`timescale 1ns/1ps
module test_sliceAluTop;

  localparam int SW    = 4;
  localparam int NS    = 2;
  localparam int DEPTH = 16;
  localparam int DW    = SW * NS;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] uAAddr = '0, uBAddr = '0;
  logic [2:0]    uSrc = 3'd2, uFunc = 3'd0, uDest = 3'd1;
  logic          uCarryIn = 1'b0;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] yOut;
  logic          carryOut, zeroFlag, signFlag, overflowFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] refRf [DEPTH];
  logic [DW-1:0] refQ;

  always #2.5 clk = ~clk;

  sliceAluTop #(.SLICE_W(SW), .NUM_SLICES(NS), .RF_DEPTH(DEPTH)) i_sliceAluTop (
    .clk(clk), .rst(rst),
    .uAAddr(uAAddr), .uBAddr(uBAddr), .uSrc(uSrc), .uFunc(uFunc),
    .uDest(uDest), .uCarryIn(uCarryIn), .dIn(dIn),
    .yOut(yOut), .carryOut(carryOut), .zeroFlag(zeroFlag),
    .signFlag(signFlag), .overflowFlag(overflowFlag)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // returns {overflow, carry, F}
  function automatic logic [DW+1:0] refAlu(input logic [DW-1:0] r, input logic [DW-1:0] s,
                                           input logic [2:0] f, input logic c);
    logic [DW:0]   sum;
    logic [DW-1:0] x, y, res;
    logic          co, ov;
    co = 1'b0; ov = 1'b0; x = r; y = s;
    if (f == 3'd1) x = ~r;
    if (f == 3'd2) y = ~s;
    case (f)
      3'd0, 3'd1, 3'd2: begin
        sum = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, c};
        res = sum[DW-1:0];
        co  = sum[DW];
        ov  = (x[DW-1] == y[DW-1]) && (res[DW-1] != x[DW-1]);
      end
      3'd3: res = r | s;
      3'd4: res = r & s;
      3'd5: res = ~r & s;
      3'd6: res = r ^ s;
      default: res = ~(r ^ s);
    endcase
    return {ov, co, res};
  endfunction

  // presents one word in the low half, samples in the next low half
  task automatic exec(input logic [AW-1:0] aA, input logic [AW-1:0] bA,
                      input logic [2:0] s, input logic [2:0] f, input logic [2:0] d,
                      input logic c, input logic [DW-1:0] dv, input string tag);
    logic [DW-1:0] av, bv, rv, sv, fe, ye;
    logic [DW+1:0] res;
    av = refRf[aA]; bv = refRf[bA];
    case (s)
      3'd0: begin rv = av; sv = refQ; end
      3'd1: begin rv = av; sv = bv;   end
      3'd2: begin rv = '0; sv = refQ; end
      3'd3: begin rv = '0; sv = bv;   end
      3'd4: begin rv = '0; sv = av;   end
      3'd5: begin rv = dv; sv = av;   end
      3'd6: begin rv = dv; sv = refQ; end
      default: begin rv = dv; sv = '0; end
    endcase
    res = refAlu(rv, sv, f, c);
    fe  = res[DW-1:0];
    ye  = (d == 3'd2) ? av : fe;
    uAAddr = aA; uBAddr = bA; uSrc = s; uFunc = f; uDest = d; uCarryIn = c;
    @(posedge clk);
    #1 dIn = dv;
    @(negedge clk);
    #1;
    check(tag, 64'({yOut, carryOut, zeroFlag, signFlag, overflowFlag}),
               64'({ye, res[DW], (fe == '0), fe[DW-1], res[DW+1]}));
    if (d == 3'd0 || d == 3'd4) refQ = fe;
    if (d == 3'd2 || d == 3'd3 || d == 3'd4) refRf[bA] = fe;
  endtask

  localparam logic [31:0] PATS [6] = '{
    32'h00000000, 32'hFF01807F, 32'h7F010FF0,
    32'h808055AA, 32'h3CC301FE, 32'hA55AFF10
  };

  initial begin
    for (int i = 0; i < DEPTH; i++) refRf[i] = '0;
    refQ = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    #1;
    // R1 reset state on the outputs
    check("R1 reset outputs", 64'({yOut, carryOut, zeroFlag, signFlag, overflowFlag}),
          64'({{DW{1'b0}}, 1'b0, 1'b1, 1'b0, 1'b0}));
    exec(4'd3, 4'd3, 3'd4, 3'd3, 3'd1, 1'b0, 8'h00, "R1 cleared entry");

    // R2 R3 R4 R5 sweep of every source, function and carry-in
    foreach (PATS[p]) begin
      exec(4'd0, 4'd1, 3'd7, 3'd3, 3'd3, 1'b0, PATS[p][31:24], "R7 load A");
      exec(4'd0, 4'd2, 3'd7, 3'd3, 3'd3, 1'b0, PATS[p][23:16], "R7 load B");
      exec(4'd0, 4'd0, 3'd7, 3'd3, 3'd0, 1'b0, PATS[p][15:8],  "R6 load Q");
      for (int s = 0; s < 8; s++)
        for (int f = 0; f < 8; f++)
          for (int c = 0; c < 2; c++)
            exec(4'd1, 4'd2, 3'(s), 3'(f), 3'd1, 1'(c), PATS[p][7:0], "R2 R3 R4 R5 sweep");
    end

    // R6 non-writing destinations leave entry and Q untouched
    exec(4'd0, 4'd7, 3'd7, 3'd3, 3'd3, 1'b0, 8'h22, "R6 load 7");
    exec(4'd0, 4'd0, 3'd7, 3'd3, 3'd0, 1'b0, 8'h44, "R6 load Q");
    exec(4'd0, 4'd7, 3'd7, 3'd3, 3'd1, 1'b0, 8'h55, "R6 nop dest");
    exec(4'd0, 4'd7, 3'd7, 3'd3, 3'd6, 1'b0, 8'h66, "R6 code 6 as nop");
    exec(4'd7, 4'd0, 3'd4, 3'd3, 3'd1, 1'b0, 8'h00, "R6 entry kept");
    exec(4'd0, 4'd0, 3'd2, 3'd3, 3'd1, 1'b0, 8'h00, "R6 Q kept");
    exec(4'd0, 4'd8, 3'd7, 3'd3, 3'd4, 1'b0, 8'h6B, "R6 dual write");
    exec(4'd8, 4'd0, 3'd4, 3'd3, 3'd1, 1'b0, 8'h00, "R6 dual entry");
    exec(4'd0, 4'd0, 3'd2, 3'd3, 3'd1, 1'b0, 8'h00, "R6 dual Q");

    // R7 write then read in the next cycle; R8 old value during the write
    exec(4'd0, 4'd6, 3'd7, 3'd3, 3'd3, 1'b0, 8'h11, "R7 load 6");
    exec(4'd6, 4'd6, 3'd7, 3'd3, 3'd2, 1'b0, 8'h99, "R8 old A shown");
    exec(4'd6, 4'd0, 3'd4, 3'd3, 3'd1, 1'b0, 8'h00, "R7 next read");
    exec(4'd5, 4'd5, 3'd1, 3'd0, 3'd3, 1'b1, 8'h00, "R8 self add");
    exec(4'd5, 4'd5, 3'd1, 3'd0, 3'd1, 1'b0, 8'h00, "R7 self add read");

    // R9 dIn reaches yOut within the cycle
    exec(4'd0, 4'd0, 3'd7, 3'd3, 3'd1, 1'b0, 8'h12, "R9 pass");
    dIn = 8'h34;
    #0.5;
    check("R9 mid-cycle dIn", 64'(yOut), 64'(8'h34));
    // R10 mid-cycle microword change ignored
    uSrc = 3'd2; uFunc = 3'd4; uAAddr = 4'd7;
    #0.3;
    check("R10 mid-cycle word", 64'(yOut), 64'(8'h34));
    exec(4'd0, 4'd0, 3'd2, 3'd3, 3'd1, 1'b0, 8'h00, "R10 next word");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule